// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home-node engine of a flat directory protocol in which every coherent line has its directory entry at its home memory. Requests from caches (read, read-exclusive, upgrade, writeback) and revision messages from a current owner (sharing writeback, downgrade, ownership transfer) arrive one per cycle on a valid/ready port. Each request names a line and a requesting node. The block looks up that line's entry and settles the new directory state in the same cycle. It also chooses the reply to the requester, any intervention or writeback-data forward to a third node, and the set of sharers to invalidate. It then writes the entry back.

Each entry holds a state, a presence vector of sharers, an owner pointer and the node waiting on a busy line. A line is made busy when a request must be completed by its owner. Any new request to a busy line is refused with a NACK and is not queued. Data from memory is sent speculatively while the owner is asked to act. A writeback that crosses an intervention in flight is merged into that busy operation. A line can also be poisoned so that every later access to it traps.

The registered response appears exactly one cycle after the request is accepted. It carries the reply kind, the requester, the new state, the forward target, the invalidation mask and its population count. Nothing else about the entry is visible from outside.

Top module: `home_dir_ctrl`

## Requirements
- R1: While reset is held, req_ready and rsp_valid are 0. After reset, req_ready is 1 and every line is unowned (state 0). A response with rsp_valid=1 appears exactly in the cycle after each accepted request and at no other time. rsp_dest repeats the requester.
- R2: A read (type 0) or read-exclusive (type 1) to an unowned line returns exclusive data (kind 1), with the requester as owner and new state exclusive (2). A read to a shared line (state 1) adds the requester to the sharers, returns shared data (kind 0) and leaves the line shared.
- R3: In busy-unowned (3), busy-shared (4) or busy-exclusive (5), any read, read-exclusive or upgrade (type 2) gets a NACK (kind 4) and the entry is left as it was.
- R4: A read to an exclusive line whose owner is another node moves the line to busy-shared and records the requester as pending. A read-exclusive in the same case moves it to busy-exclusive. Both reply with speculative data (kind 3) and forward an intervention to the owner (rsp_fwd_valid=1, rsp_fwd_node = owner). A read or read-exclusive from the owner itself returns kind 1 and the line stays exclusive.
- R5: An upgrade gets a NACK (kind 4) when the line is unowned or exclusive, and when the line is shared but the requester is not one of its sharers.
- R6: A read-exclusive, or an upgrade from a sharer, to a shared line makes the requester exclusive owner. Read-exclusive replies with kind 1 and upgrade with kind 2. rsp_inv_mask (bit i = node i) lists every prior sharer except the requester, and rsp_inv_count equals its population count. Every other response has an empty mask.
- R7: A writeback (type 3) from the owner of an exclusive line moves it to unowned and returns a writeback ack (kind 5) with no forward.
- R8: A writeback from the owner while the line is busy-shared gives shared, with the pending node as the only sharer. While busy-exclusive it gives exclusive, with the pending node as owner. Either way the reply is kind 5, with the data forwarded to the pending node (rsp_fwd_valid=1). Forwards occur only with kinds 3 and 5.
- R9: A sharing writeback (type 4) or downgrade (type 5) from the owner ends busy-shared as shared, with owner and pending node as sharers. An ownership transfer (type 6) from the owner ends busy-exclusive as exclusive, owned by the pending node. Both return kind 6.
- R10: A writeback or revision that arrives in a state it does not complete, or from a node other than the recorded owner, returns kind 8 and leaves the entry unchanged.
- R11: A poison mark (type 7) on an unowned line moves it to poisoned (6) with kind 6. On any other non-poisoned line it gets a NACK. Every request of any type to a poisoned line returns kind 7, and the line stays poisoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_type | input | 3 | Request or revision type code |
| req_line | input | $clog2(N_LINES) | Line index at this home |
| req_node | input | $clog2(N_NODES) | Requesting node |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 4 | Reply kind code |
| rsp_dest | output | $clog2(N_NODES) | Node the reply goes to |
| rsp_state | output | 3 | Directory state after the request |
| rsp_fwd_valid | output | 1 | Intervention or writeback data forward present |
| rsp_fwd_node | output | $clog2(N_NODES) | Target of the forward |
| rsp_inv_mask | output | N_NODES | Sharers to invalidate |
| rsp_inv_count | output | $clog2(N_NODES)+1 | Number of invalidations |

## Verification
The directed part drives the crossing race, where the owner's writeback arrives after the line has gone busy. A design that refuses or drops that writeback strands the pending requester, and one that ends in the wrong state hands the line to the wrong node. The directed part also covers an upgrade from a node that has already lost its copy, which a faulty design would grant without data. It checks that the requester is excluded from its own invalidation mask; otherwise the count of acks the requester waits for comes out one too high. Revisions from a non-owner, back-to-back requests to one line, and poisoning are also covered: corrupting the entry there shows up as a wrong state or a wrong forward target later in the same line's history. Seeded random sequences concentrated on a few lines then compare every response field against a bench-side model.

// File: rtl/dir_pkg.sv
`timescale 1ns/1ps
// Shared codes of the home directory controller.
// Assumes: the encodings below are visible on the top module ports.
package dir_pkg;

    typedef enum logic [2:0] {
        RQ_READ  = 3'd0,
        RQ_RDEX  = 3'd1,
        RQ_UPG   = 3'd2,
        RQ_WB    = 3'd3,
        RQ_SHWB  = 3'd4,
        RQ_DOWN  = 3'd5,
        RQ_XFER  = 3'd6,
        RQ_PMARK = 3'd7
    } req_e;

    typedef enum logic [2:0] {
        ST_UNOWNED = 3'd0,
        ST_SHARED  = 3'd1,
        ST_EXCL    = 3'd2,
        ST_BSY_UN  = 3'd3,
        ST_BSY_SH  = 3'd4,
        ST_BSY_EX  = 3'd5,
        ST_POISON  = 3'd6
    } dir_state_e;

    typedef enum logic [3:0] {
        RSP_DATA_SH = 4'd0,
        RSP_DATA_EX = 4'd1,
        RSP_UPG_ACK = 4'd2,
        RSP_SPEC    = 4'd3,
        RSP_NACK    = 4'd4,
        RSP_WB_ACK  = 4'd5,
        RSP_DONE    = 4'd6,
        RSP_POISON  = 4'd7,
        RSP_ERR     = 4'd8
    } rsp_e;

endpackage

// File: rtl/dir_store.sv
`timescale 1ns/1ps
// Directory entry array: one packed entry per line.
// Assumes: one asynchronous read port and one synchronous write port. An
// all-zero entry means unowned with no sharers.
module dir_store #(
    parameter int DEPTH = 16,
    parameter int W     = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [W-1:0]             rd_data,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [W-1:0]             wr_data
);
    logic [W-1:0] ent_q [DEPTH];

    // Clear every entry on reset; otherwise store the committed update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else if (wr_en) begin
            ent_q[wr_idx] <= wr_data;
        end
    end

    // Present the addressed entry to the decision logic.
    assign rd_data = ent_q[rd_idx];
endmodule

// File: rtl/dir_popcnt.sv
`timescale 1ns/1ps
// Population count of the invalidation mask.
// Assumes: CW is wide enough to hold N.
module dir_popcnt #(
    parameter int N  = 8,
    parameter int CW = 4
) (
    input  logic [N-1:0]  vec,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] part [N+1];

    assign part[0] = '0;
    for (genvar i = 0; i < N; i++) begin : g_acc
        // Add one mask bit to the running count.
        assign part[i+1] = part[i] + CW'(vec[i]);
    end
    assign cnt = part[N];
endmodule

// File: rtl/dir_decide.sv
`timescale 1ns/1ps
// Next-state and action decision for one directory entry.
// Assumes: one request per call. Owner and pending fields are meaningful
// only in exclusive and busy states. Purely combinational.
module dir_decide
    import dir_pkg::*;
#(
    parameter int N_NODES = 8,
    localparam int NW     = $clog2(N_NODES)
) (
    input  req_e               typ,
    input  logic [NW-1:0]      node,
    input  dir_state_e         cur_st,
    input  logic [N_NODES-1:0] cur_sh,
    input  logic [NW-1:0]      cur_own,
    input  logic [NW-1:0]      cur_pend,
    output dir_state_e         nxt_st,
    output logic [N_NODES-1:0] nxt_sh,
    output logic [NW-1:0]      nxt_own,
    output logic [NW-1:0]      nxt_pend,
    output logic               commit,
    output rsp_e               kind,
    output logic               fwd_v,
    output logic [NW-1:0]      fwd_n,
    output logic [N_NODES-1:0] inv
);
    localparam logic [N_NODES-1:0] ONE = N_NODES'(1);

    logic [N_NODES-1:0] req_bit;
    logic [N_NODES-1:0] own_bit;
    logic [N_NODES-1:0] pend_bit;
    logic               is_owner;
    logic               busy;

    // Decode node numbers into presence-vector positions.
    always_comb begin
        req_bit  = ONE << node;
        own_bit  = ONE << cur_own;
        pend_bit = ONE << cur_pend;
        is_owner = (cur_own == node);
        busy     = (cur_st == ST_BSY_UN) || (cur_st == ST_BSY_SH) || (cur_st == ST_BSY_EX);
    end

    // Choose the transition, the reply and any forward or invalidation.
    always_comb begin
        nxt_st   = cur_st;
        nxt_sh   = cur_sh;
        nxt_own  = cur_own;
        nxt_pend = cur_pend;
        commit   = 1'b0;
        kind     = RSP_ERR;
        fwd_v    = 1'b0;
        fwd_n    = cur_own;
        inv      = '0;
        if (cur_st == ST_POISON) begin
            kind = RSP_POISON;
        end else if (busy && (typ == RQ_READ || typ == RQ_RDEX || typ == RQ_UPG || typ == RQ_PMARK)) begin
            kind = RSP_NACK;
        end else begin
            case (typ)
                RQ_READ, RQ_RDEX: begin
                    if (cur_st == ST_UNOWNED) begin
                        nxt_st  = ST_EXCL;
                        nxt_own = node;
                        nxt_sh  = '0;
                        commit  = 1'b1;
                        kind    = RSP_DATA_EX;
                    end else if (cur_st == ST_SHARED && typ == RQ_READ) begin
                        nxt_sh = cur_sh | req_bit;
                        commit = 1'b1;
                        kind   = RSP_DATA_SH;
                    end else if (cur_st == ST_SHARED) begin
                        inv     = cur_sh & ~req_bit;
                        nxt_st  = ST_EXCL;
                        nxt_own = node;
                        nxt_sh  = '0;
                        commit  = 1'b1;
                        kind    = RSP_DATA_EX;
                    end else if (is_owner) begin
                        kind = RSP_DATA_EX;
                    end else begin
                        nxt_st   = (typ == RQ_READ) ? ST_BSY_SH : ST_BSY_EX;
                        nxt_pend = node;
                        commit   = 1'b1;
                        kind     = RSP_SPEC;
                        fwd_v    = 1'b1;
                        fwd_n    = cur_own;
                    end
                end
                RQ_UPG: begin
                    if (cur_st == ST_SHARED && cur_sh[node]) begin
                        inv     = cur_sh & ~req_bit;
                        nxt_st  = ST_EXCL;
                        nxt_own = node;
                        nxt_sh  = '0;
                        commit  = 1'b1;
                        kind    = RSP_UPG_ACK;
                    end else begin
                        kind = RSP_NACK;
                    end
                end
                RQ_WB: begin
                    if (is_owner && cur_st == ST_EXCL) begin
                        nxt_st = ST_UNOWNED;
                        nxt_sh = '0;
                        commit = 1'b1;
                        kind   = RSP_WB_ACK;
                    end else if (is_owner && cur_st == ST_BSY_SH) begin
                        nxt_st = ST_SHARED;
                        nxt_sh = pend_bit;
                        commit = 1'b1;
                        kind   = RSP_WB_ACK;
                        fwd_v  = 1'b1;
                        fwd_n  = cur_pend;
                    end else if (is_owner && cur_st == ST_BSY_EX) begin
                        nxt_st  = ST_EXCL;
                        nxt_own = cur_pend;
                        commit  = 1'b1;
                        kind    = RSP_WB_ACK;
                        fwd_v   = 1'b1;
                        fwd_n   = cur_pend;
                    end
                end
                RQ_SHWB, RQ_DOWN: begin
                    if (is_owner && cur_st == ST_BSY_SH) begin
                        nxt_st = ST_SHARED;
                        nxt_sh = own_bit | pend_bit;
                        commit = 1'b1;
                        kind   = RSP_DONE;
                    end
                end
                RQ_XFER: begin
                    if (is_owner && cur_st == ST_BSY_EX) begin
                        nxt_st  = ST_EXCL;
                        nxt_own = cur_pend;
                        commit  = 1'b1;
                        kind    = RSP_DONE;
                    end
                end
                RQ_PMARK: begin
                    if (cur_st == ST_UNOWNED) begin
                        nxt_st = ST_POISON;
                        commit = 1'b1;
                        kind   = RSP_DONE;
                    end else begin
                        kind = RSP_NACK;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/home_dir_ctrl.sv
`timescale 1ns/1ps
// Home directory coherence controller.
// Looks up the addressed entry, decides the transition in the same cycle,
// writes it back, and registers the response for the next cycle.
// Assumes: N_LINES and N_NODES are powers of two; one request per cycle.
module home_dir_ctrl
    import dir_pkg::*;
#(
    parameter int N_NODES = 8,
    parameter int N_LINES = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [2:0]                   req_type,
    input  logic [$clog2(N_LINES)-1:0]   req_line,
    input  logic [$clog2(N_NODES)-1:0]   req_node,
    output logic                         rsp_valid,
    output logic [3:0]                   rsp_kind,
    output logic [$clog2(N_NODES)-1:0]   rsp_dest,
    output logic [2:0]                   rsp_state,
    output logic                         rsp_fwd_valid,
    output logic [$clog2(N_NODES)-1:0]   rsp_fwd_node,
    output logic [N_NODES-1:0]           rsp_inv_mask,
    output logic [$clog2(N_NODES):0]     rsp_inv_count
);
    localparam int NW = $clog2(N_NODES);
    localparam int CW = NW + 1;
    localparam int EW = 3 + N_NODES + 2 * NW;

    logic [EW-1:0]      rd_ent;
    logic [EW-1:0]      wr_ent;
    logic [2:0]         cur_st_raw;
    dir_state_e         cur_st;
    logic [N_NODES-1:0] cur_sh;
    logic [NW-1:0]      cur_own;
    logic [NW-1:0]      cur_pend;
    dir_state_e         nxt_st;
    logic [N_NODES-1:0] nxt_sh;
    logic [NW-1:0]      nxt_own;
    logic [NW-1:0]      nxt_pend;
    logic               dec_commit;
    rsp_e               dec_kind;
    logic               dec_fwd_v;
    logic [NW-1:0]      dec_fwd_n;
    logic [N_NODES-1:0] dec_inv;
    logic [CW-1:0]      dec_cnt;
    logic               accept;

    assign accept = req_valid && req_ready;

    // Split the stored entry into its fields.
    assign {cur_st_raw, cur_sh, cur_own, cur_pend} = rd_ent;
    assign cur_st = dir_state_e'(cur_st_raw);
    assign wr_ent = {nxt_st, nxt_sh, nxt_own, nxt_pend};

    dir_store #(.DEPTH(N_LINES), .W(EW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (req_line),
        .rd_data (rd_ent),
        .wr_en   (accept && dec_commit),
        .wr_idx  (req_line),
        .wr_data (wr_ent)
    );

    dir_decide #(.N_NODES(N_NODES)) u_decide (
        .typ      (req_e'(req_type)),
        .node     (req_node),
        .cur_st   (cur_st),
        .cur_sh   (cur_sh),
        .cur_own  (cur_own),
        .cur_pend (cur_pend),
        .nxt_st   (nxt_st),
        .nxt_sh   (nxt_sh),
        .nxt_own  (nxt_own),
        .nxt_pend (nxt_pend),
        .commit   (dec_commit),
        .kind     (dec_kind),
        .fwd_v    (dec_fwd_v),
        .fwd_n    (dec_fwd_n),
        .inv      (dec_inv)
    );

    dir_popcnt #(.N(N_NODES), .CW(CW)) u_popcnt (
        .vec (dec_inv),
        .cnt (dec_cnt)
    );

    // Open the request port once reset has been released.
    always_ff @(posedge clk) begin
        if (!rst_n) req_ready <= 1'b0;
        else        req_ready <= 1'b1;
    end

    // Register the response of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_kind      <= '0;
            rsp_dest      <= '0;
            rsp_state     <= '0;
            rsp_fwd_valid <= 1'b0;
            rsp_fwd_node  <= '0;
            rsp_inv_mask  <= '0;
            rsp_inv_count <= '0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_kind      <= dec_kind;
                rsp_dest      <= req_node;
                rsp_state     <= dec_commit ? nxt_st : cur_st;
                rsp_fwd_valid <= dec_fwd_v;
                rsp_fwd_node  <= dec_fwd_n;
                rsp_inv_mask  <= dec_inv;
                rsp_inv_count <= dec_cnt;
            end
        end
    end

    // R1
    rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);

    // R1
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !rsp_valid);

    // R3
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (cur_st == ST_BSY_UN || cur_st == ST_BSY_SH || cur_st == ST_BSY_EX)
         && (req_type == RQ_READ || req_type == RQ_RDEX || req_type == RQ_UPG))
        |=> (rsp_kind == RSP_NACK && rsp_state == $past(cur_st_raw)));

    // R6
    inv_excludes_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !rsp_inv_mask[rsp_dest]);

    // R6
    inv_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_inv_count == CW'($countones(rsp_inv_mask))));

    // R8
    fwd_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fwd_valid) |-> (rsp_kind == RSP_SPEC || rsp_kind == RSP_WB_ACK));

    // R11
    poison_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cur_st == ST_POISON) |=> (rsp_kind == RSP_POISON && rsp_state == ST_POISON));
endmodule

// File: tb/home_dir_ctrl_bench.sv
`timescale 1ns/1ps
module home_dir_ctrl_bench;
    localparam int NN = 8;
    localparam int NL = 16;

    localparam logic [2:0] T_RD = 0, T_RX = 1, T_UP = 2, T_WB = 3, T_SW = 4, T_DG = 5, T_XF = 6, T_PM = 7;
    localparam logic [2:0] S_UN = 0, S_SH = 1, S_EX = 2, S_BS = 4, S_BE = 5, S_PO = 6;
    localparam logic [3:0] K_DS = 0, K_DX = 1, K_UA = 2, K_SP = 3, K_NK = 4, K_WA = 5, K_DN = 6, K_PO = 7, K_ER = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [2:0] req_type = '0;
    logic [3:0] req_line = '0;
    logic [2:0] req_node = '0;
    logic       rsp_valid;
    logic [3:0] rsp_kind;
    logic [2:0] rsp_dest;
    logic [2:0] rsp_state;
    logic       rsp_fwd_valid;
    logic [2:0] rsp_fwd_node;
    logic [7:0] rsp_inv_mask;
    logic [3:0] rsp_inv_count;

    int tests = 0;
    int fails = 0;

    logic [2:0] m_st   [NL];
    logic [7:0] m_sh   [NL];
    logic [2:0] m_own  [NL];
    logic [2:0] m_pend [NL];

    always #2.5 clk = ~clk;

    home_dir_ctrl #(.N_NODES(NN), .N_LINES(NL)) u_home_dir_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_type(req_type), .req_line(req_line), .req_node(req_node),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_dest(rsp_dest),
        .rsp_state(rsp_state), .rsp_fwd_valid(rsp_fwd_valid), .rsp_fwd_node(rsp_fwd_node),
        .rsp_inv_mask(rsp_inv_mask), .rsp_inv_count(rsp_inv_count)
    );

    // Expected behaviour written from the requirements; updates the model entry.
    task automatic predict(input logic [2:0] t, input logic [3:0] ln, input logic [2:0] nd,
                           output logic [3:0] k, output logic [2:0] s, output logic fv,
                           output logic [2:0] fn, output logic [7:0] mk);
        logic [2:0] s0;
        logic       own;
        logic [7:0] me;
        s0  = m_st[ln];
        own = (m_own[ln] == nd);
        me  = 8'd1 << nd;
        k = K_ER; fv = 1'b0; fn = '0; mk = '0;
        if (s0 == S_PO) begin
            k = K_PO;
        end else if (t == T_RD || t == T_RX || t == T_UP) begin
            if (s0 == 3 || s0 == S_BS || s0 == S_BE) k = K_NK;
            else if (t == T_UP) begin
                if (s0 == S_SH && m_sh[ln][nd]) begin
                    mk = m_sh[ln] & ~me; m_st[ln] = S_EX; m_own[ln] = nd; m_sh[ln] = '0; k = K_UA;
                end else k = K_NK;
            end else if (s0 == S_UN) begin
                m_st[ln] = S_EX; m_own[ln] = nd; m_sh[ln] = '0; k = K_DX;
            end else if (s0 == S_SH && t == T_RD) begin
                m_sh[ln] = m_sh[ln] | me; k = K_DS;
            end else if (s0 == S_SH) begin
                mk = m_sh[ln] & ~me; m_st[ln] = S_EX; m_own[ln] = nd; m_sh[ln] = '0; k = K_DX;
            end else if (own) begin
                k = K_DX;
            end else begin
                m_st[ln] = (t == T_RD) ? S_BS : S_BE; m_pend[ln] = nd; k = K_SP; fv = 1'b1; fn = m_own[ln];
            end
        end else if (t == T_WB) begin
            if (own && s0 == S_EX) begin
                m_st[ln] = S_UN; m_sh[ln] = '0; k = K_WA;
            end else if (own && s0 == S_BS) begin
                m_st[ln] = S_SH; m_sh[ln] = 8'd1 << m_pend[ln]; k = K_WA; fv = 1'b1; fn = m_pend[ln];
            end else if (own && s0 == S_BE) begin
                m_st[ln] = S_EX; m_own[ln] = m_pend[ln]; k = K_WA; fv = 1'b1; fn = m_pend[ln];
            end
        end else if (t == T_SW || t == T_DG) begin
            if (own && s0 == S_BS) begin
                m_st[ln] = S_SH; m_sh[ln] = me | (8'd1 << m_pend[ln]); k = K_DN;
            end
        end else if (t == T_XF) begin
            if (own && s0 == S_BE) begin
                m_st[ln] = S_EX; m_own[ln] = m_pend[ln]; k = K_DN;
            end
        end else begin
            if (s0 == S_UN) begin m_st[ln] = S_PO; k = K_DN; end
            else k = K_NK;
        end
        s = m_st[ln];
    endtask

    // Issue one request and compare the whole response against the model.
    task automatic send(input logic [2:0] t, input logic [3:0] ln, input logic [2:0] nd, input string tag);
        logic [3:0] k; logic [2:0] s; logic fv; logic [2:0] fn; logic [7:0] mk;
        predict(t, ln, nd, k, s, fv, fn, mk);
        @(negedge clk);
        req_type = t; req_line = ln; req_node = nd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        tests++;
        if (!rsp_valid || rsp_kind != k || rsp_state != s || rsp_dest != nd ||
            rsp_fwd_valid != fv || (fv && rsp_fwd_node != fn) ||
            rsp_inv_mask != mk || rsp_inv_count != 4'($countones(mk))) begin
            fails++;
            $display("FAIL %s t=%0d line=%0d node=%0d: got v=%0b kind=%0d st=%0d fwd=%0b/%0d mask=%h cnt=%0d, expected kind=%0d st=%0d fwd=%0b/%0d mask=%h",
                     tag, t, ln, nd, rsp_valid, rsp_kind, rsp_state, rsp_fwd_valid, rsp_fwd_node,
                     rsp_inv_mask, rsp_inv_count, k, s, fv, fn, mk);
        end
    endtask

    task automatic quiet_check(input logic exp_ready, input string tag);
        tests++;
        if (req_ready != exp_ready || rsp_valid != 1'b0) begin
            fails++;
            $display("FAIL %s: ready=%0b valid=%0b, expected ready=%0b valid=0", tag, req_ready, rsp_valid, exp_ready);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NL; i++) begin
            m_st[i] = S_UN; m_sh[i] = '0; m_own[i] = '0; m_pend[i] = '0;
        end
        void'($urandom(32'h5eed_0d1c));
        repeat (3) @(negedge clk);
        quiet_check(1'b0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        quiet_check(1'b1, "R1 after reset");
        send(T_RD, 9, 6, "R1 unowned after reset");

        // Line 0: exclusive, crossing reads, revisions, upgrades.
        send(T_RD, 0, 1, "R2 read unowned");
        send(T_RD, 0, 1, "R4 owner reread");
        send(T_RD, 0, 3, "R4 read to other owner");
        send(T_RD, 0, 4, "R3 read while busy");
        send(T_RX, 0, 5, "R3 rdex while busy");
        send(T_UP, 0, 1, "R3 upgrade while busy");
        send(T_SW, 0, 1, "R9 sharing writeback");
        send(T_RD, 0, 6, "R2 read shared");
        send(T_UP, 0, 2, "R5 upgrade from non-sharer");
        send(T_UP, 0, 3, "R6 upgrade from sharer");
        send(T_WB, 0, 1, "R10 writeback from non-owner");
        send(T_RX, 0, 0, "R4 rdex to other owner");
        send(T_WB, 0, 3, "R8 merged writeback busy-exclusive");
        send(T_XF, 0, 0, "R10 transfer outside busy");
        send(T_WB, 0, 0, "R7 writeback exclusive");
        send(T_UP, 0, 0, "R5 upgrade unowned");
        send(T_RX, 0, 2, "R2 rdex unowned");
        send(T_UP, 0, 2, "R5 upgrade exclusive");

        // Line 2: merged writeback in busy-shared, invalidation fan-out, transfer.
        send(T_RD, 2, 1, "R2 read unowned");
        send(T_RD, 2, 2, "R4 read to other owner");
        send(T_DG, 2, 2, "R10 downgrade from non-owner");
        send(T_WB, 2, 1, "R8 merged writeback busy-shared");
        send(T_RD, 2, 5, "R2 read shared");
        send(T_RD, 2, 0, "R2 read shared");
        send(T_RX, 2, 7, "R6 rdex shared");
        send(T_RX, 2, 4, "R4 rdex to other owner");
        send(T_SW, 2, 7, "R10 sharing writeback in busy-exclusive");
        send(T_XF, 2, 7, "R9 ownership transfer");
        send(T_RX, 2, 5, "R4 forward names new owner");
        send(T_DG, 2, 4, "R10 downgrade in busy-exclusive");
        send(T_XF, 2, 4, "R9 ownership transfer");
        send(T_RD, 2, 6, "R4 read to other owner");
        send(T_DG, 2, 5, "R9 downgrade");
        send(T_RX, 2, 6, "R6 rdex shared by requester");

        // Line 3 and 0: poisoning.
        send(T_PM, 3, 0, "R11 poison unowned");
        send(T_RD, 3, 4, "R11 read poisoned");
        send(T_WB, 3, 0, "R11 writeback poisoned");
        send(T_PM, 0, 2, "R11 poison exclusive refused");
        send(T_PM, 3, 1, "R11 poison poisoned");

        // Seeded random traffic on a few hot lines.
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] t; logic [3:0] ln; logic [2:0] nd;
            ln = ($urandom % 8 == 0) ? 4'($urandom % NL) : 4'(4 + $urandom % 4);
            t  = ($urandom % 256 == 0) ? T_PM : 3'($urandom % 7);
            if (t >= T_WB && t <= T_XF && ($urandom % 2 == 0)) nd = m_own[ln];
            else nd = 3'($urandom % NN);
            send(t, ln, nd, "RND");
        end

        @(negedge clk);
        quiet_check(1'b1, "R1 idle");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule